// File: doc/BRIEF.md
# Monochrome Glyph Expansion Blitter

The block turns 1-bit-per-pixel bitmap words into 8-bit pixels in a linear frame buffer. Software loads a foreground colour, a background colour, a plane mask, a line pitch in bytes and a span: a row `y0` and the columns `x0` to `x1`. Writing a 32-bit glyph word starts the expansion. Bit 31 of the word becomes the pixel at `x0`, bit 30 the pixel at `x0+1`, and so on. A set bit takes the foreground colour and a clear bit takes the background colour. The number of pixels is `x1 - x0 + 1`, capped at 32. Only the leading bits of a short span are drawn.

After each glyph word the block adds a column step register to `x0` and a row step register to `y0`. A text line can therefore be streamed as a series of glyph writes without reprogramming the span. Pixels leave through a single-beat request port with a valid/ready handshake. With a full plane mask each pixel is one write. With any other mask each pixel is a read followed by a write that keeps the unmasked bits of the old byte.

The controller is a four-state machine:
- `ST_IDLE` accepts register writes. On a glyph write it goes to `ST_STEP` when the span is empty, to `ST_WRITE` when the mask is full, and to `ST_READ` otherwise.
- `ST_READ` captures the old byte on the read handshake and moves to `ST_WRITE`.
- `ST_WRITE`, on the write handshake, returns to `ST_READ` or `ST_WRITE` for the next pixel. After the last pixel it goes to `ST_STEP`.
- `ST_STEP` applies the column and row steps and returns to `ST_IDLE`.

Top module: `glyph_blit`

## Requirements
- R1: After reset the block is idle (`busy`=0, `mem_valid`=0, `wr_ready`=1), the column step is 32, and every other register is 0.
- R2: A pixel whose glyph bit is 1 takes the foreground colour (register 0). A pixel whose bit is 0 takes the background colour (register 1).
- R3: Glyph bit 31 maps to column `x0`, and each lower bit maps to the next higher column.
- R4: The pixel count is `x1 - x0 + 1`, limited to 32. When `x1 < x0` no pixel is touched. Low bits beyond the count are ignored.
- R5: After every glyph word, `x0` grows by the column step (register 7) and `y0` grows by the row step (register 8). This also happens for an empty span.
- R6: The address of the pixel at column x is `y0 * pitch + x`. The pitch is register 3.
- R7: Only bits set in the plane mask (register 2) change. The other bits of the byte keep their old frame buffer value.
- R8: With the plane mask at 0xFF, no read request is issued. With any other mask, exactly one read is issued per drawn pixel.
- R9: While an expansion runs, `busy` is 1 and `wr_ready` is 0. A write presented then is held and takes effect once the block is idle.
- R10: A pixel request keeps its address, direction and data unchanged until `mem_ready` accepts it.
- R11: Register select codes are: 0 fg, 1 bg, 2 plane mask, 3 pitch, 4 y0, 5 x0, 6 x1, 7 column step, 8 row step, 9 glyph word (which starts the expansion).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_sel | input | 4 | Register select (R11) |
| wr_data | input | 32 | Write data; full width for the glyph word |
| busy | output | 1 | Expansion in progress |
| mem_valid | output | 1 | Pixel request valid |
| mem_ready | input | 1 | Pixel request accepted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 24 | Byte address in the frame buffer |
| mem_wdata | output | 8 | Pixel byte to write |
| mem_rdata | input | 8 | Old byte, valid during an accepted read |

## Verification
The assertions check the following on every cycle:
- request hold under stall;
- the absence of reads with a full mask;
- preservation of unmasked bits against the byte just read;
- quiet outputs when idle;
- the write back-pressure while busy.

The bench compares the whole frame buffer against an arithmetic model after every glyph word, with a stalling memory. This is the only way to show colour selection, bit-to-column order, span truncation, the address formula and the step advance. These depend on sequences of pixels, not on single cycles.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_STEP  = 2'd3
    } gstate_t;

    localparam int SELW = 4;
    localparam logic [SELW-1:0] SEL_FG    = 4'd0;
    localparam logic [SELW-1:0] SEL_BG    = 4'd1;
    localparam logic [SELW-1:0] SEL_PMASK = 4'd2;
    localparam logic [SELW-1:0] SEL_PITCH = 4'd3;
    localparam logic [SELW-1:0] SEL_Y0    = 4'd4;
    localparam logic [SELW-1:0] SEL_X0    = 4'd5;
    localparam logic [SELW-1:0] SEL_X1    = 4'd6;
    localparam logic [SELW-1:0] SEL_XSTEP = 4'd7;
    localparam logic [SELW-1:0] SEL_YSTEP = 4'd8;
    localparam logic [SELW-1:0] SEL_GLYPH = 4'd9;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
    import glyph_pkg::*;
#(
    parameter int XW    = 11,
    parameter int YW    = 11,
    parameter int PW    = 12,
    parameter int PXW   = 8,
    parameter int RW    = 12,
    parameter int WORDW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [SELW-1:0] sel,
    input  logic [RW-1:0]   wdata,
    input  logic            advance,
    output logic [PXW-1:0]  fg,
    output logic [PXW-1:0]  bg,
    output logic [PXW-1:0]  pmask,
    output logic [PW-1:0]   pitch,
    output logic [YW-1:0]   y0,
    output logic [XW-1:0]   x0,
    output logic [XW-1:0]   x1,
    output logic [XW-1:0]   xstep,
    output logic [YW-1:0]   ystep
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg    <= '0;
            bg    <= '0;
            pmask <= '0;
            pitch <= '0;
            y0    <= '0;
            x0    <= '0;
            x1    <= '0;
            xstep <= XW'(WORDW);
            ystep <= '0;
        end else if (advance) begin
            x0 <= x0 + xstep;
            y0 <= y0 + ystep;
        end else if (we) begin
            unique case (sel)
                SEL_FG:    fg    <= wdata[PXW-1:0];
                SEL_BG:    bg    <= wdata[PXW-1:0];
                SEL_PMASK: pmask <= wdata[PXW-1:0];
                SEL_PITCH: pitch <= wdata[PW-1:0];
                SEL_Y0:    y0    <= wdata[YW-1:0];
                SEL_X0:    x0    <= wdata[XW-1:0];
                SEL_X1:    x1    <= wdata[XW-1:0];
                SEL_XSTEP: xstep <= wdata[XW-1:0];
                SEL_YSTEP: ystep <= wdata[YW-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/glyph_span.sv
module glyph_span #(
    parameter int XW    = 11,
    parameter int WORDW = 32,
    parameter int CW    = 6
) (
    input  logic [XW-1:0] x0,
    input  logic [XW-1:0] x1,
    output logic [CW-1:0] count
);
    logic [XW:0] diff;

    always_comb begin
        diff = {1'b0, x1} - {1'b0, x0};
        if (diff[XW])
            count = '0;
        else if (diff[XW-1:0] >= XW'(WORDW - 1))
            count = CW'(WORDW);
        else
            count = CW'(diff) + CW'(1);
    end
endmodule

// File: rtl/glyph_pixel.sv
module glyph_pixel #(
    parameter int PXW = 8
) (
    input  logic           bit_in,
    input  logic [PXW-1:0] fg,
    input  logic [PXW-1:0] bg,
    input  logic [PXW-1:0] pmask,
    input  logic [PXW-1:0] old_px,
    output logic [PXW-1:0] new_px
);
    logic [PXW-1:0] colour;

    always_comb begin
        colour = bit_in ? fg : bg;
        new_px = (colour & pmask) | (old_px & ~pmask);
    end
endmodule

// File: rtl/glyph_blit.sv
module glyph_blit
    import glyph_pkg::*;
#(
    parameter int XW    = 11,
    parameter int YW    = 11,
    parameter int PW    = 12,
    parameter int PXW   = 8,
    parameter int WORDW = 32,
    parameter int AW    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [3:0]       wr_sel,
    input  logic [WORDW-1:0] wr_data,
    output logic             busy,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [PXW-1:0]   mem_wdata,
    input  logic [PXW-1:0]   mem_rdata
);
    localparam int RW = imax(imax(XW, YW), imax(PW, PXW));
    localparam int CW = $clog2(WORDW + 1);

    gstate_t st, st_nx;

    logic [PXW-1:0]   fg, bg, plane_mask, old_q;
    logic [PW-1:0]    pitch;
    logic [YW-1:0]    y0, ystep;
    logic [XW-1:0]    x0, x1, xstep, xcur_q;
    logic [WORDW-1:0] word_q;
    logic [CW-1:0]    left_q, span_cnt;
    logic             reg_we, glyph_go, mask_full, advance;

    assign reg_we    = wr_valid && wr_ready;
    assign glyph_go  = reg_we && (wr_sel == SEL_GLYPH);
    assign mask_full = &plane_mask;
    assign advance   = (st == ST_STEP);

    glyph_regs #(
        .XW(XW), .YW(YW), .PW(PW), .PXW(PXW), .RW(RW), .WORDW(WORDW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .sel(wr_sel),
        .wdata(wr_data[RW-1:0]), .advance(advance),
        .fg(fg), .bg(bg), .pmask(plane_mask), .pitch(pitch),
        .y0(y0), .x0(x0), .x1(x1), .xstep(xstep), .ystep(ystep)
    );

    glyph_span #(.XW(XW), .WORDW(WORDW), .CW(CW)) u_span (
        .x0(x0), .x1(x1), .count(span_cnt)
    );

    glyph_pixel #(.PXW(PXW)) u_pix (
        .bit_in(word_q[WORDW-1]), .fg(fg), .bg(bg), .pmask(plane_mask),
        .old_px(old_q), .new_px(mem_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (glyph_go) begin
                    if (span_cnt == '0)  st_nx = ST_STEP;
                    else if (mask_full)  st_nx = ST_WRITE;
                    else                 st_nx = ST_READ;
                end
            end
            ST_READ: begin
                if (mem_ready) st_nx = ST_WRITE;
            end
            ST_WRITE: begin
                if (mem_ready) begin
                    if (left_q == CW'(1)) st_nx = ST_STEP;
                    else if (mask_full)   st_nx = ST_WRITE;
                    else                  st_nx = ST_READ;
                end
            end
            ST_STEP: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_ready  = (st == ST_IDLE);
        busy      = (st != ST_IDLE);
        mem_valid = (st == ST_READ) || (st == ST_WRITE);
        mem_we    = (st == ST_WRITE);
        mem_addr  = AW'(y0) * AW'(pitch) + AW'(xcur_q);
    end

    // pixel datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            left_q <= '0;
            xcur_q <= '0;
            old_q  <= '0;
        end else begin
            if (glyph_go) begin
                word_q <= wr_data;
                left_q <= span_cnt;
                xcur_q <= x0;
            end
            if (st == ST_READ && mem_ready)
                old_q <= mem_rdata;
            if (st == ST_WRITE && mem_ready) begin
                word_q <= word_q << 1;
                left_q <= left_q - CW'(1);
                xcur_q <= xcur_q + XW'(1);
            end
        end
    end
endmodule

// File: rtl/glyph_chk.sv
module glyph_chk #(
    parameter int AW  = 24,
    parameter int PXW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           wr_valid,
    input logic           wr_ready,
    input logic [3:0]     wr_sel,
    input logic           busy,
    input logic           mem_valid,
    input logic           mem_ready,
    input logic           mem_we,
    input logic [AW-1:0]  mem_addr,
    input logic [PXW-1:0] mem_wdata,
    input logic [PXW-1:0] mem_rdata,
    input logic [PXW-1:0] plane_mask
);
    logic [PXW-1:0] last_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) last_rd <= '0;
        else if (mem_valid && mem_ready && !mem_we) last_rd <= mem_rdata;
    end

    p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_we) && $stable(mem_wdata));

    p_no_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && (plane_mask == '1) |-> mem_we);

    p_keep_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we && (plane_mask != '1)
            |-> ((mem_wdata ^ last_rd) & ~plane_mask) == '0);

    p_stall_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_ready);

    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready && (wr_sel == 4'd9) |=> busy);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_valid);
endmodule

bind glyph_blit glyph_chk #(.AW(AW), .PXW(PXW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .plane_mask(plane_mask)
);

// File: tb/sim_glyph_blit.sv
module sim_glyph_blit;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_valid = 0;
    logic        wr_ready;
    logic [3:0]  wr_sel = 0;
    logic [31:0] wr_data = 0;
    logic        busy, mem_valid, mem_ready, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    glyph_blit u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_sel(wr_sel), .wr_data(wr_data), .busy(busy),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    logic [7:0] fbm [4096];
    logic [7:0] expm[4096];
    logic [4:0] lf = 5'h1f;
    int rd_cnt = 0;
    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    assign mem_ready = lf[0] | lf[3];
    assign mem_rdata = fbm[mem_addr[11:0]];

    always @(posedge clk) begin
        lf <= {lf[3:0], lf[4] ^ lf[2]};
        if (mem_valid && mem_ready) begin
            if (mem_we) fbm[mem_addr[11:0]] <= mem_wdata;
            else        rd_cnt <= rd_cnt + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            bad = bad + 1; total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // bench copy of the programmed state
    int bfg = 0, bbg = 0, bpm = 0, bpitch = 0, by0 = 0, bx0 = 0, bx1 = 0;
    int bxs = 32, bys = 0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        wr_valid = 1; wr_sel = 4'(sel); wr_data = d;
        while (!wr_ready) @(negedge clk);
        @(negedge clk);
        wr_valid = 0;
    endtask

    // R11 select codes
    task automatic setr(input int sel, input int v);
        wr(sel, 32'(v));
        case (sel)
            0: bfg = v & 255;  1: bbg = v & 255;  2: bpm = v & 255;
            3: bpitch = v;     4: by0 = v;        5: bx0 = v;
            6: bx1 = v;        7: bxs = v;        8: bys = v;
            default: ;
        endcase
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic model(input logic [31:0] w);
        int n = bx1 - bx0 + 1;
        if (n > 32) n = 32;
        for (int i = 0; i < n; i++) begin
            int a = (by0 * bpitch + bx0 + i) & 4095;
            int col = w[31-i] ? bfg : bbg;
            expm[a] = 8'((col & bpm) | (expm[a] & ~bpm));
        end
        bx0 = bx0 + bxs;
        by0 = by0 + bys;
    endtask

    task automatic cmp(input string req);
        int miss = 0, first = -1;
        for (int a = 0; a < 4096; a++)
            if (fbm[a] !== expm[a]) begin
                miss++;
                if (first < 0) first = a;
            end
        if (miss != 0)
            chk(0, req, int'(fbm[first]), int'(expm[first]));
        else
            chk(1, req, 0, 0);
    endtask

    task automatic draw(input logic [31:0] w, input string req);
        int r0 = rd_cnt;
        int n = bx1 - bx0 + 1;
        if (n > 32) n = 32;
        if (n < 0) n = 0;
        model(w);
        wr(9, w);
        wait_idle();
        cmp(req);
        // R8 read count
        chk((rd_cnt - r0) == ((bpm == 255) ? 0 : n), "R8 reads",
            rd_cnt - r0, (bpm == 255) ? 0 : n);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) begin
            fbm[a]  = 8'(a * 7 + 3);
            expm[a] = 8'(a * 7 + 3);
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !mem_valid && wr_ready, "R1 reset idle",
            {busy, mem_valid, wr_ready}, 1);

        // R1: default column step 32 used without programming it
        setr(3, 64); setr(0, 8'hC3); setr(1, 8'h18); setr(2, 255);
        setr(4, 2); setr(5, 0); setr(6, 100);
        draw(32'hF0F0_1234, "R1 R2 R3 default step");
        draw(32'h8000_0001, "R1 R5 second word at x0+32");

        // sweep of span widths and masks: R2 R3 R4 R6 R7
        for (int m = 0; m < 3; m++) begin
            int pm = (m == 0) ? 255 : (m == 1) ? 8'h3C : 8'hA5;
            setr(2, pm);
            for (int w = 1; w <= 34; w++) begin
                setr(0, (w * 13) & 255);
                setr(1, (w * 29 + 7) & 255);
                setr(4, 5 + (w % 20));
                setr(5, 3 + (w % 5));
                setr(6, 3 + (w % 5) + w - 1);
                draw(32'h9E37_79B9 * 32'(w + m), "R4 R6 R7 span sweep");
            end
        end

        // R4 empty span, and R5 advance still applied
        setr(2, 255); setr(4, 10); setr(5, 40); setr(6, 20);
        draw(32'hFFFF_FFFF, "R4 empty span untouched");
        setr(6, 200);
        draw(32'h0F0F_0F0F, "R5 advance after empty span");

        // R5 custom steps
        setr(7, 5); setr(8, 2); setr(4, 30); setr(5, 96); setr(6, 300);
        draw(32'hDEAD_BEEF, "R5 step a");
        draw(32'h1357_9BDF, "R5 step b");
        setr(2, 8'h0F);
        draw(32'hAAAA_5555, "R5 R7 step c");

        // R9 back-pressure: write during busy waits, then takes effect
        setr(2, 255); setr(7, 32); setr(8, 0); setr(4, 40); setr(5, 0); setr(6, 31);
        model(32'hFFFF_0000);
        wr(9, 32'hFFFF_0000);
        @(negedge clk);
        chk(busy && !wr_ready, "R9 busy blocks writes", {busy, wr_ready}, 2);
        setr(0, 8'h5A);
        chk(!busy, "R9 held write done after idle", busy, 0);
        setr(5, 0); setr(4, 41);
        draw(32'hFFFF_FFFF, "R9 held fg applied");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule